// File: doc/BRIEF.md
# 1-Wire Slave Time-Slot Responder

This block handles the slave side of a 1-Wire bus, one bit at a time. A slot starts when the master pulls the open-drain line low. The block passes the raw line level through a two-flop synchronizer and looks for a high-to-low transition. It then times the slot with a cycle counter whose limits come from the clock frequency parameter.

In receive mode the block reads the line once, at a fixed point inside the master's write window. It reports the bit with a one-cycle strobe. In transmit mode it takes one bit through a ready/valid handshake at the moment a slot starts. To send a 0 it pulls the line low for a fixed hold time and then releases it. To send a 1 it leaves the line alone. At the end of each slot the block stays inert until it has seen the line high again. A held-low line therefore always counts as a single slot.

Reset/presence handling, byte assembly and command decoding are done by neighbouring logic.

Top module: `ow_slot_responder`

## Requirements
- R1: During reset and right after it, `pull_low`, `rx_valid` and `tx_ready` are 0.
- R2: `bus_in` passes through two flops before edge detection. A slot starts on a high-to-low transition seen at the synchronizer output. `pull_low` for a transmitted 0 goes high on the third rising clock edge after the line falls.
- R3: In receive mode, the synchronized line level 30 µs (SAMPLE_US) after slot detection is reported on `rx_bit` (high = 1, low = 0), with `rx_valid` high for exactly one cycle per slot.
- R4: In transmit mode, a bit value of 0 drives `pull_low` high from the cycle after detection until 45 µs (HOLD_US) after it, after which the line is released. A bit value of 1 leaves `pull_low` at 0.
- R5: `tx_ready` is high only in the cycle in which a slot start is detected while `mode_tx` is 1. A bit is consumed only if `tx_valid` is high in that cycle. Without a valid bit the line stays released for the whole slot. Outside slots the line is never pulled, whatever `tx_valid` holds.
- R6: 60 µs (SLOT_US) after detection, the block ignores the line until it has been seen high. A low period of any length produces exactly one slot.
- R7: In receive mode `pull_low` and `tx_ready` stay 0. In transmit mode no `rx_valid` is produced.
- R8: A second falling edge inside an active slot does not start a new slot or produce a second capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock of frequency CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_in | input | 1 | Raw line level (1 = released/high) |
| mode_tx | input | 1 | 1 = transmit mode, 0 = receive mode; latched at slot start |
| tx_valid | input | 1 | Transmit bit available |
| tx_bit | input | 1 | Bit to send in the next read slot |
| tx_ready | output | 1 | Transmit bit taken this cycle (when tx_valid) |
| rx_valid | output | 1 | One-cycle strobe: rx_bit holds a captured bit |
| rx_bit | output | 1 | Bit captured from a write slot |
| pull_low | output | 1 | Open-drain enable: 1 pulls the line low |

## Verification
The bench builds the block with CLK_HZ = 1 MHz, so that one clock cycle counts as one microsecond. With that setting the 30 µs sample point, the 45 µs release and the 60 µs slot end fall on exact cycle numbers that the reference model can predict. A full slot then takes only about 80 cycles, which leaves room for master pulses ending just before and just after the sample point, a line held low for 150 µs, and a second pulse inside a live slot. Timings are otherwise unchanged from the default build.

// File: rtl/ow_slot_responder.sv
module ow_slot_responder #(
  parameter int unsigned CLK_HZ    = 50_000_000,
  parameter int unsigned SAMPLE_US = 30,
  parameter int unsigned HOLD_US   = 45,
  parameter int unsigned SLOT_US   = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_in,
  input  logic mode_tx,
  input  logic tx_valid,
  input  logic tx_bit,
  output logic tx_ready,
  output logic rx_valid,
  output logic rx_bit,
  output logic pull_low
);
  localparam int unsigned CYC_PER_MS = CLK_HZ / 1000;
  localparam int unsigned SAMPLE_CYC = CYC_PER_MS * SAMPLE_US / 1000;
  localparam int unsigned HOLD_CYC   = CYC_PER_MS * HOLD_US / 1000;
  localparam int unsigned SLOT_CYC   = CYC_PER_MS * SLOT_US / 1000;
  localparam int unsigned CW         = $clog2(SLOT_CYC + 1);
  localparam logic [CW-1:0] SAMPLE_LAST = CW'(SAMPLE_CYC - 1);
  localparam logic [CW-1:0] HOLD_LAST   = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] SLOT_LAST   = CW'(SLOT_CYC - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SLOT, ST_REARM} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          s1, s2, s_prev;
  logic          tx_slot;
  logic          fall;

  assign fall     = s_prev & ~s2;
  assign tx_ready = (st == ST_IDLE) & fall & mode_tx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1       <= 1'b1;
      s2       <= 1'b1;
      s_prev   <= 1'b1;
      st       <= ST_IDLE;
      cnt      <= '0;
      tx_slot  <= 1'b0;
      pull_low <= 1'b0;
      rx_valid <= 1'b0;
      rx_bit   <= 1'b0;
    end else begin
      s1       <= bus_in;
      s2       <= s1;
      s_prev   <= s2;
      rx_valid <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (fall) begin
            st       <= ST_SLOT;
            cnt      <= '0;
            tx_slot  <= mode_tx;
            pull_low <= mode_tx & tx_valid & ~tx_bit;
          end
        end
        ST_SLOT: begin
          cnt <= cnt + 1'b1;
          if (!tx_slot && cnt == SAMPLE_LAST) begin
            rx_valid <= 1'b1;
            rx_bit   <= s2;
          end
          if (cnt == HOLD_LAST) pull_low <= 1'b0;
          if (cnt == SLOT_LAST) st <= ST_REARM;
        end
        ST_REARM: begin
          if (s2) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R2
  pull_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pull_low) |-> $past(fall && mode_tx));

  // R4
  pull_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pull_low |-> (st == ST_SLOT && tx_slot && cnt <= HOLD_LAST));

  // R3
  rx_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R7
  rx_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !tx_slot);

  // R5
  tx_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |=> (st == ST_SLOT));

  // R6
  rearm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_REARM && !s2) |=> (st == ST_REARM));

  // R8
  inslot_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SLOT && fall && cnt != SLOT_LAST) |=> (st == ST_SLOT && cnt != '0));
endmodule

// File: tb/tb_ow_slot_responder.sv
module tb_ow_slot_responder;
  localparam int SMP = 30, HLD = 45, SLT = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_low = 1'b0;
  logic mode_tx = 1'b0, tx_valid = 1'b0, tx_bit = 1'b1;
  logic tx_ready, rx_valid, rx_bit, pull_low;
  logic bus_in;
  int total = 0, bad = 0;
  bit run = 1'b0;
  logic got[$];

  always #10 clk = ~clk;
  assign bus_in = ~(m_low | pull_low);

  ow_slot_responder #(.CLK_HZ(1_000_000)) dut (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .mode_tx(mode_tx),
    .tx_valid(tx_valid), .tx_bit(tx_bit), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_bit(rx_bit), .pull_low(pull_low));

  task automatic chk(string rq, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", rq, act, exp, $time);
    end
  endtask

  // behavioural reference
  logic m1 = 1, m2 = 1, mp = 1, m_pull = 0, m_rxv = 0, m_rxb = 0, m_txs = 0;
  int ph = 0, tc = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m1 = 1; m2 = 1; mp = 1; m_pull = 0; m_rxv = 0; m_rxb = 0; m_txs = 0; ph = 0; tc = 0;
    end else begin
      logic line;
      logic edge_seen;
      line = ~(m_low | m_pull);
      edge_seen = mp && !m2;
      m_rxv = 0;
      if (ph == 0) begin
        if (edge_seen) begin
          ph = 1; tc = 0; m_txs = mode_tx;
          m_pull = mode_tx && tx_valid && !tx_bit;
        end
      end else if (ph == 1) begin
        tc++;
        if (!m_txs && tc == SMP) begin m_rxv = 1; m_rxb = m2; end
        if (tc == HLD) m_pull = 0;
        if (tc == SLT) ph = 2;
      end else if (m2) ph = 0;
      mp = m2; m2 = m1; m1 = line;
    end
  end

  always @(negedge clk) if (run) begin
    chk("R4 pull_low", pull_low, m_pull);
    chk("R3 rx_valid", rx_valid, m_rxv);
    if (m_rxv) chk("R3 rx_bit", rx_bit, m_rxb);
    chk("R5 tx_ready", tx_ready, ph == 0 && mp && !m2 && mode_tx);
    if (rx_valid) got.push_back(rx_bit);
  end

  task automatic wslot(int low, int rest);
    @(negedge clk) m_low = 1;
    repeat (low) @(negedge clk);
    m_low = 0;
    repeat (rest) @(negedge clk);
  endtask

  task automatic rslot(logic b, logic v, output logic seen);
    tx_bit = b; tx_valid = v;
    @(negedge clk) m_low = 1;
    repeat (2) @(negedge clk);
    m_low = 0;
    repeat (4) @(negedge clk);
    tx_valid = 0;
    repeat (9) @(negedge clk);
    seen = bus_in;
    repeat (70) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic s;
    logic exp_q[$];
    repeat (3) @(negedge clk);
    chk("R1 pull_low", pull_low, 1'b0);
    chk("R1 rx_valid", rx_valid, 1'b0);
    chk("R1 tx_ready", tx_ready, 1'b0);
    rst_n = 1'b1;
    run = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 pull_low after", pull_low, 1'b0);

    // R3: receive, pulses around the sample point
    wslot(5, 80);  exp_q.push_back(1);
    wslot(60, 20); exp_q.push_back(0);
    wslot(20, 60); exp_q.push_back(1);
    wslot(35, 45); exp_q.push_back(0);
    wslot(2, 80);  exp_q.push_back(1);
    chk("R3 count", got.size() == exp_q.size(), 1'b1);
    foreach (exp_q[i]) if (i < got.size()) chk("R3 bit", got[i], exp_q[i]);

    // R6: long low yields one slot
    got.delete();
    wslot(150, 20);
    chk("R6 one capture", got.size() == 1, 1'b1);
    if (got.size() > 0) chk("R6 bit", got[0], 1'b0);

    // R8: second edge inside a slot
    got.delete();
    wslot(3, 37);
    wslot(3, 60);
    chk("R8 one capture", got.size() == 1, 1'b1);
    if (got.size() > 0) chk("R8 bit", got[0], 1'b1);

    // R7: receive mode ignores transmit data
    rslot(1'b0, 1'b1, s);
    chk("R7 rx mode no pull", s, 1'b1);

    // R4/R5: transmit mode
    got.delete();
    mode_tx = 1'b1;
    rslot(1'b0, 1'b1, s); chk("R4 send 0", s, 1'b0);
    rslot(1'b1, 1'b1, s); chk("R4 send 1", s, 1'b1);
    rslot(1'b0, 1'b0, s); chk("R5 no valid released", s, 1'b1);
    rslot(1'b0, 1'b1, s); chk("R2 send 0 again", s, 1'b0);
    chk("R7 tx mode no rx", got.size() == 0, 1'b1);

    // R5: valid data without a slot
    tx_bit = 1'b0; tx_valid = 1'b1;
    repeat (100) @(negedge clk);
    chk("R5 idle no pull", pull_low, 1'b0);
    chk("R5 idle no ready", tx_ready, 1'b0);
    rslot(1'b0, 1'b1, s); chk("R5 first slot after wait", s, 1'b0);
    repeat (10) @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule